// File: doc/BRIEF.md
# Chip-Enable Framed Serial Command Port

This block is the host-facing serial slave of a segment display controller with a key matrix. A host drives a serial clock, a data line and a chip-enable line. With chip-enable low the host shifts in an 8-bit address. With chip-enable high it then either writes one quarter of the display image, together with control fields, or reads the confirmed key state. Every serial line is sampled by the block's system clock, and each serial edge is detected inside the block. The output line models an open-drain pin: a 1 means released (pulled high) and a 0 means driven low.

The data-out pin has a second job. Between frames it tells the host that a confirmed key press is waiting, by going low. Inside a write frame it is released. The block also holds the display and key logic in reset after a power-on detection. That reset ends only once all four display parts have been loaded, and only while the external reset pin is high. The shift logic and the control register are left out of that functional reset, so the host can load the image while the reset is still active.

Top module: `cmd_frame_port`

## Requirements
- R1: With `ser_ce` low, address bits are taken on each rising `ser_clk`, least significant bit first. When `ser_ce` rises, the last 8 bits taken select the frame: 0x42 is a display/control write, 0x43 is a key read. Any other address leaves the display latch and control outputs unchanged.
- R2: A write frame is 64 bits, with frame bit i being the i-th bit received. Bits 63:62 carry the part index k, with bit 62 as the LSB. Frame bits 0 up to w-1 go to `disp_latch[56*k + i]`, where w is 56 for parts 0 to 2 and 52 for part 3. The other display bits keep their values.
- R3: A write frame that does not hold exactly 64 bits when `ser_ce` falls changes neither `disp_latch` nor the control outputs.
- R4: Only part 3 loads the control outputs, from frame bits 52 to 60 in this order: `sleep_sel[0]`, `sleep_sel[1]`, `scan_sel[0]`, `scan_sel[1]`, `port_sel[0]`, `port_sel[1]`, `port_sel[2]`, `seg_off`, `half_bias`.
- R5: In a read frame, `ser_dout` shows key bit 1 (`key_bits[0]`) first and moves on to the next bit after each falling `ser_clk`. After the 30 key bits comes a sleep-acknowledge bit, which is 1 when either `sleep_sel` bit is set and 0 otherwise. After that the line is released.
- R6: A read frame that starts while no request is valid (`key_pending` low, or `sys_rst` high) shifts out 31 ones.
- R7: While `ser_ce` is low and `sys_rst` is low, `ser_dout` equals the inverse of `key_pending`. While `ser_ce` is high in a frame that is not a read, `ser_dout` is 1.
- R8: `read_ack` pulses high for one clock cycle, on the clock edge that detects the falling `ser_ce` which ends a read frame that began with a valid request. It stays low otherwise.
- R9: After `rst_n` or a `por_det` pulse, `sys_rst` stays high until `ser_ce` falls at the end of a valid write frame that completes all four parts since that event. After that, `sys_rst` stays high only while `res_n` is low.
- R10: `sys_rst` is high whenever `res_n` is low, and `ser_dout` is 1 whenever `sys_rst` is high, even with a request pending or during a read.
- R11: Write frames update `disp_latch` and the control outputs while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| por_det | input | 1 | One-cycle power-on detection pulse |
| res_n | input | 1 | External reset pin, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_ce | input | 1 | Chip-enable that frames a transfer |
| key_pending | input | 1 | A confirmed key press is waiting, from the key scanner |
| key_bits | input | 30 | Confirmed key state, key 1 in bit 0 |
| ser_dout | output | 1 | Open-drain data out / read request (1 = released) |
| read_ack | output | 1 | Pulse: key data was read by the host |
| disp_latch | output | 220 | Display image latch |
| sleep_sel | output | 2 | Sleep control field |
| scan_sel | output | 2 | Key-line / segment select field |
| port_sel | output | 3 | General-purpose port select field |
| seg_off | output | 1 | All segments off |
| half_bias | output | 1 | Bias select (1 = half bias) |
| sys_rst | output | 1 | Functional reset for display and key logic |

## Verification
Write frames are sent with a different bit pattern for each of the four parts, so a part index or base offset that is decoded wrongly puts bits in the wrong slice of the latch. Frames one bit short, one bit long, and frames sent to a foreign address carry patterns that would visibly change the latch, so a discard that fails shows up. Read frames use an asymmetric 30-bit key word: with sleep off and on, with a request pending and with none, and during reset. This separates bit order, the position of the acknowledge bit and the all-ones invalid reply. The reset sequence is tried with the reset pin high and low at the moment the fourth part lands, and again after a second power-on pulse.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  localparam int ADDR_W = 8;

  typedef struct packed {
    logic       half_bias;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] scan_sel;
    logic [1:0] sleep_sel;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

  // width of display part k
  function automatic int part_width(int k, int parts, int part_bits, int total);
    return (k == parts - 1) ? total - part_bits * (parts - 1) : part_bits;
  endfunction

  // which part a display bit belongs to
  function automatic int part_of_bit(int b, int part_bits);
    return b / part_bits;
  endfunction

  function automatic logic sleep_ack(logic [1:0] sleep);
    return |sleep;
  endfunction

endpackage

// File: rtl/cfp_rx.sv
module cfp_rx #(
  parameter int                FRAME_BITS = 64,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR    = 8'h42,
  parameter logic [ADDR_W-1:0] RD_ADDR    = 8'h43
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  ser_din,
  input  logic                  ser_ce,
  output logic                  clk_fall,
  output logic                  ce_fall,
  output logic                  rd_start,
  output logic                  rd_end,
  output logic                  wr_commit,
  output logic [FRAME_BITS-1:0] frame
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic              sclk_q, ce_q;
  logic              clk_rise, ce_rise;
  logic [ADDR_W-1:0] addr_sr, frame_addr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_wr;

  assign clk_rise = ser_clk & ~sclk_q;
  assign clk_fall = ~ser_clk & sclk_q;
  assign ce_rise  = ser_ce & ~ce_q;
  assign ce_fall  = ~ser_ce & ce_q;
  assign in_wr    = (frame_addr == WR_ADDR);

  assign rd_start  = ce_rise && (addr_sr == RD_ADDR);
  assign rd_end    = ce_fall && (frame_addr == RD_ADDR);
  assign wr_commit = ce_fall && in_wr && (bit_cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      ce_q       <= 1'b0;
      addr_sr    <= '0;
      frame_addr <= '0;
      bit_cnt    <= '0;
      frame      <= '0;
    end else begin
      sclk_q <= ser_clk;
      ce_q   <= ser_ce;
      if (!ser_ce && clk_rise)
        addr_sr <= {ser_din, addr_sr[ADDR_W-1:1]};
      if (ce_rise) begin
        frame_addr <= addr_sr;
        bit_cnt    <= '0;
      end else if (ser_ce && clk_rise) begin
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        if (in_wr) frame <= {ser_din, frame[FRAME_BITS-1:1]};
      end
    end
  end

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT);                                            // R3
  AST_COMMIT_ON_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !ser_ce && !rd_end);                              // R2

endmodule

// File: rtl/cfp_store.sv
module cfp_store
  import cfp_pkg::*;
#(
  parameter int DISP_BITS  = 220,
  parameter int PARTS      = 4,
  parameter int PART_BITS  = 56,
  parameter int FRAME_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_det,
  input  logic                  res_n,
  input  logic                  wr_commit,
  input  logic [FRAME_BITS-1:0] frame,
  output logic [DISP_BITS-1:0]  disp,
  output ctrl_t                 ctrl,
  output logic                  sys_rst
);
  localparam int DIR_W  = $clog2(PARTS);
  localparam int LAST_W = part_width(PARTS - 1, PARTS, PART_BITS, DISP_BITS);

  logic [DIR_W-1:0] part;
  logic [PARTS-1:0] part_hot, loaded_q, loaded_nx;
  logic             por_hold;
  logic             last_part;
  ctrl_t            ctrl_d;

  assign part      = frame[FRAME_BITS-1 -: DIR_W];
  assign part_hot  = PARTS'(1) << part;
  assign loaded_nx = loaded_q | part_hot;
  assign last_part = (part == DIR_W'(PARTS - 1));

  always_comb begin
    for (int j = 0; j < CTRL_BITS; j++) ctrl_d[j] = frame[LAST_W + j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp <= '0;
      ctrl <= '0;
    end else if (wr_commit) begin
      for (int b = 0; b < DISP_BITS; b++)
        if (part == DIR_W'(part_of_bit(b, PART_BITS)))
          disp[b] <= frame[b % PART_BITS];
      if (last_part) ctrl <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      por_hold <= 1'b1;
    end else if (por_det) begin
      loaded_q <= '0;
      por_hold <= 1'b1;
    end else if (wr_commit) begin
      loaded_q <= loaded_nx;
      if (&loaded_nx) por_hold <= 1'b0;
    end
  end

  assign sys_rst = por_hold | ~res_n;

  AST_CTRL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && last_part) |=> $stable(ctrl));                   // R4
  AST_DISP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(disp));                                  // R3
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_hold) |-> $past(wr_commit));                          // R9

endmodule

// File: rtl/cfp_tx.sv
module cfp_tx #(
  parameter int KEY_BITS = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_ce,
  input  logic                clk_fall,
  input  logic                ce_fall,
  input  logic                rd_start,
  input  logic                rd_end,
  input  logic                sys_rst,
  input  logic                key_pending,
  input  logic [KEY_BITS-1:0] key_bits,
  input  logic                sack,
  output logic                ser_dout,
  output logic                read_ack
);
  localparam int READ_BITS = KEY_BITS + 1;

  logic [READ_BITS-1:0] read_sr;
  logic                 rd_active, rd_valid, req_ok;

  assign req_ok = key_pending & ~sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_sr   <= '1;
      rd_active <= 1'b0;
      rd_valid  <= 1'b0;
      read_ack  <= 1'b0;
    end else begin
      read_ack <= rd_end & rd_valid;
      if (rd_start) begin
        rd_active <= 1'b1;
        rd_valid  <= req_ok;
        read_sr   <= req_ok ? {sack, key_bits} : '1;
      end else if (ce_fall) begin
        rd_active <= 1'b0;
        rd_valid  <= 1'b0;
      end else if (rd_active && clk_fall) begin
        read_sr <= {1'b1, read_sr[READ_BITS-1:1]};
      end
    end
  end

  always_comb begin
    if (sys_rst)     ser_dout = 1'b1;
    else if (ser_ce) ser_dout = rd_active ? read_sr[0] : 1'b1;
    else             ser_dout = ~key_pending;
  end

  AST_DOUT_HIGH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> ser_dout);                                          // R10
  AST_WRITE_FRAME_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ce && !rd_active |-> ser_dout);                             // R7
  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    read_ack |-> $past(rd_end));                                    // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    read_ack |=> !read_ack);                                        // R8

endmodule

// File: rtl/cmd_frame_port.sv
module cmd_frame_port
  import cfp_pkg::*;
#(
  parameter int                DISP_BITS  = 220,
  parameter int                PARTS      = 4,
  parameter int                PART_BITS  = 56,
  parameter int                FRAME_BITS = 64,
  parameter int                KEY_BITS   = 30,
  parameter logic [ADDR_W-1:0] WR_ADDR    = 8'h42,
  parameter logic [ADDR_W-1:0] RD_ADDR    = 8'h43
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_det,
  input  logic                 res_n,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  input  logic                 ser_ce,
  input  logic                 key_pending,
  input  logic [KEY_BITS-1:0]  key_bits,
  output logic                 ser_dout,
  output logic                 read_ack,
  output logic [DISP_BITS-1:0] disp_latch,
  output logic [1:0]           sleep_sel,
  output logic [1:0]           scan_sel,
  output logic [2:0]           port_sel,
  output logic                 seg_off,
  output logic                 half_bias,
  output logic                 sys_rst
);
  logic                  clk_fall, ce_fall, rd_start, rd_end, wr_commit;
  logic [FRAME_BITS-1:0] frame;
  ctrl_t                 ctrl;
  logic                  sack;

  cfp_rx #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W),
           .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) rx_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_ce(ser_ce), .clk_fall(clk_fall), .ce_fall(ce_fall),
    .rd_start(rd_start), .rd_end(rd_end), .wr_commit(wr_commit),
    .frame(frame));

  cfp_store #(.DISP_BITS(DISP_BITS), .PARTS(PARTS), .PART_BITS(PART_BITS),
              .FRAME_BITS(FRAME_BITS)) store_i (
    .clk(clk), .rst_n(rst_n), .por_det(por_det), .res_n(res_n),
    .wr_commit(wr_commit), .frame(frame), .disp(disp_latch),
    .ctrl(ctrl), .sys_rst(sys_rst));

  assign sack = sleep_ack(ctrl.sleep_sel);

  cfp_tx #(.KEY_BITS(KEY_BITS)) tx_i (
    .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .clk_fall(clk_fall),
    .ce_fall(ce_fall), .rd_start(rd_start), .rd_end(rd_end),
    .sys_rst(sys_rst), .key_pending(key_pending), .key_bits(key_bits),
    .sack(sack), .ser_dout(ser_dout), .read_ack(read_ack));

  assign sleep_sel = ctrl.sleep_sel;
  assign scan_sel  = ctrl.scan_sel;
  assign port_sel  = ctrl.port_sel;
  assign seg_off   = ctrl.seg_off;
  assign half_bias = ctrl.half_bias;

  AST_PIN_LOW_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n |-> sys_rst && ser_dout);                                // R10
  AST_REQUEST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_ce && !sys_rst |-> ser_dout == !key_pending);              // R7

endmodule

// File: tb/cmd_frame_port_tb_top.sv
module cmd_frame_port_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         por_det = 1'b0;
  logic         res_n = 1'b1;
  logic         ser_clk = 1'b0;
  logic         ser_din = 1'b0;
  logic         ser_ce = 1'b0;
  logic         key_pending = 1'b0;
  logic [29:0]  key_bits = 30'h25A3C0F1;
  logic         ser_dout, read_ack, seg_off, half_bias, sys_rst;
  logic [219:0] disp_latch;
  logic [1:0]   sleep_sel, scan_sel;
  logic [2:0]   port_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit mon_rd = 0;
  bit exp_q[$];
  logic [219:0] exp_disp = '0;
  logic [8:0]   exp_ctl = '0;

  always #5 clk = ~clk;

  cmd_frame_port dut_i (
    .clk(clk), .rst_n(rst_n), .por_det(por_det), .res_n(res_n),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_ce(ser_ce),
    .key_pending(key_pending), .key_bits(key_bits), .ser_dout(ser_dout),
    .read_ack(read_ack), .disp_latch(disp_latch), .sleep_sel(sleep_sel),
    .scan_sel(scan_sel), .port_sel(port_sel), .seg_off(seg_off),
    .half_bias(half_bias), .sys_rst(sys_rst));

  task automatic check(string tag, logic [219:0] act, logic [219:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_din = b; tick(1);
    ser_clk = 1'b1; tick(1);
    ser_clk = 1'b0; tick(1);
  endtask

  task automatic send_addr(logic [7:0] a);
    ser_ce = 1'b0;
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    tick(1);
    ser_ce = 1'b1;
    tick(3);
  endtask

  // Monitor: compares each read bit on the rising serial clock
  always @(posedge ser_clk) begin
    if (ser_ce && mon_rd) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 extra read bit actual=%0b expected=none", ser_dout);
      end else begin
        check("R5/R6 read bit", 220'(ser_dout), 220'(exp_q.pop_front()));
      end
    end
  end

  // Driver for write frames: builds the frame and updates the model
  task automatic wr_frame(logic [7:0] addr, int part, logic [55:0] data,
                          logic [8:0] ctl, int nbits, bit mid_chk);
    logic [63:0] vec = '0;
    int w = (part == 3) ? 52 : 56;
    for (int i = 0; i < w; i++) vec[i] = data[i];
    if (part == 3) for (int j = 0; j < 9; j++) vec[52 + j] = ctl[j];
    vec[62] = part[0];
    vec[63] = part[1];
    send_addr(addr);
    for (int i = 0; i < nbits; i++) begin
      send_bit(i < 64 ? vec[i] : 1'b1);
      if (mid_chk && i == 10) check("R7 dout released in write frame", 220'(ser_dout), 220'(1));
    end
    ser_ce = 1'b0;
    tick(3);
    if (addr == 8'h42 && nbits == 64) begin
      for (int b = 0; b < 220; b++) if (b / 56 == part) exp_disp[b] = vec[b % 56];
      if (part == 3) exp_ctl = ctl;
    end
  endtask

  // Driver for read frames: pushes the expected bits into the queue
  task automatic rd_frame(bit valid);
    if (valid) begin
      for (int i = 0; i < 30; i++) exp_q.push_back(key_bits[i]);
      exp_q.push_back(exp_ctl[0] | exp_ctl[1]);
    end else begin
      for (int i = 0; i < 31; i++) exp_q.push_back(1'b1);
    end
    send_addr(8'h43);
    mon_rd = 1;
    for (int i = 0; i < 31; i++) send_bit(1'b0);
    mon_rd = 0;
    ser_ce = 1'b0;
    tick(1);
    check("R8 read_ack after read end", 220'(read_ack), 220'(valid));
    tick(1);
    check("R8 read_ack single cycle", 220'(read_ack), 220'(0));
    tick(2);
  endtask

  task automatic check_state(string tag);
    check({tag, " display latch"}, disp_latch, exp_disp);
    check({tag, " control"}, 220'({half_bias, seg_off, port_sel, scan_sel, sleep_sel}),
          220'(exp_ctl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    por_det = 1'b1; tick(1); por_det = 1'b0;
    tick(2);
    // reset state
    check("R9 sys_rst after power-on", 220'(sys_rst), 220'(1));
    check("R10 dout released in reset", 220'(ser_dout), 220'(1));
    check("R8 no ack at reset", 220'(read_ack), 220'(0));
    key_pending = 1'b1;
    tick(1);
    check("R10 dout released with request during reset", 220'(ser_dout), 220'(1));
    rd_frame(0);                                   // R6 R10: read in reset
    // three parts: reset persists, data lands during reset
    wr_frame(8'h42, 0, 56'hA1B2C3D4E5F607, '0, 64, 0);
    wr_frame(8'h42, 1, 56'h0F1E2D3C4B5A69, '0, 64, 0);
    wr_frame(8'h42, 2, 56'h96877869504132, '0, 64, 0);
    check("R9 held after three parts", 220'(sys_rst), 220'(1));
    check_state("R2 R11 parts 0-2");
    // fourth part with pin low
    res_n = 1'b0;
    wr_frame(8'h42, 3, 56'h00_5AC3_9E17_B24D, 9'b1_0_011_01_00, 64, 0);
    check("R9 pin low keeps reset", 220'(sys_rst), 220'(1));
    check_state("R4 R11 part 3");
    check("R4 port_sel field", 220'(port_sel), 220'(3));
    res_n = 1'b1;
    tick(1);
    check("R9 release on pin high", 220'(sys_rst), 220'(0));
    // request line
    key_pending = 1'b0; tick(1);
    check("R7 dout high without request", 220'(ser_dout), 220'(1));
    key_pending = 1'b1; tick(1);
    check("R7 dout low with request", 220'(ser_dout), 220'(0));
    // length and address filters
    wr_frame(8'h42, 1, 56'hFFFFFFFFFFFFFF, '0, 63, 1);
    check_state("R3 short frame");
    wr_frame(8'h42, 1, 56'h00000000000000, '0, 65, 0);
    check_state("R3 long frame");
    wr_frame(8'h44, 0, 56'h123456789ABCDE, '0, 64, 0);
    check_state("R1 foreign address");
    wr_frame(8'h42, 1, 56'hC0FFEE00BADA55, '0, 64, 0);
    check_state("R2 rewrite part 1");
    // reads
    rd_frame(1);                                   // R5 sleep ack 0
    wr_frame(8'h42, 3, 56'h00_1111_2222_3333, 9'b0_1_100_10_10, 64, 0);
    check("R4 sleep_sel field", 220'(sleep_sel), 220'(2));
    key_bits = 30'h0ABCD123;
    rd_frame(1);                                   // R5 sleep ack 1
    key_pending = 1'b0;
    rd_frame(0);                                   // R6 no request
    // pin reset
    key_pending = 1'b1;
    res_n = 1'b0; tick(1);
    check("R10 pin low forces reset", 220'(sys_rst), 220'(1));
    check("R10 dout released in pin reset", 220'(ser_dout), 220'(1));
    wr_frame(8'h42, 0, 56'h55AA55AA55AA55, '0, 64, 0);
    check_state("R11 write during pin reset");
    res_n = 1'b1; tick(1);
    check("R10 pin high releases", 220'(sys_rst), 220'(0));
    // second power-on event
    por_det = 1'b1; tick(1); por_det = 1'b0; tick(1);
    check("R9 power-on event sets reset", 220'(sys_rst), 220'(1));
    wr_frame(8'h42, 2, 56'h01020304050607, '0, 64, 0);
    wr_frame(8'h42, 3, 56'h00_0000_0000_0001, exp_ctl, 64, 0);
    wr_frame(8'h42, 0, 56'h08090A0B0C0D0E, '0, 64, 0);
    check("R9 three parts after second event", 220'(sys_rst), 220'(1));
    wr_frame(8'h42, 1, 56'h0F101112131415, '0, 64, 0);
    check("R9 released after all four parts", 220'(sys_rst), 220'(0));
    check_state("R2 final image");
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R5 unread bits actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule